// File: doc/BRIEF.md
# Software-Loaded Page Translation Buffer

This block holds a small, fully associative set of page mappings and uses them to turn virtual addresses into physical addresses. Pages are 4 KB. The upper 20 bits of an address select the page and the lower 12 bits are the offset within it. When translation is switched on, every fetch, load or store is checked against the entry for its page. A missing entry, or one without the needed permission, raises a fault with a two-bit cause code. The faulting word address and that cause are then captured in the trap address register.

No hardware walks a page table. Software loads the buffer by hand. It first places the virtual page in the trap address register, then writes a mapping word that carries the physical page number and the permission flags. Reading the mapping register returns the entry for the page held in the trap address register. A write whose global flag is set and whose valid flag is clear empties the whole buffer. When translation is off, addresses pass through unchanged and no access can fault.

Top module: `ptb_top`

## Requirements
- R1: After reset, no page has an entry, the trap address register reads 0, and the replacement pointer selects slot 0.
- R2: With `xlate_on` low, `acc_paddr` equals `acc_vaddr` and `acc_fault` stays low for any access.
- R3: With `xlate_on` high and an entry present for bits 31..12 of `acc_vaddr`, `acc_paddr` is that entry's physical page in bits 31..12 followed by the unchanged 12-bit offset. In every other case `acc_paddr` equals `acc_vaddr`.
- R4: A valid access with `xlate_on` high faults under the following rules. The access kind is encoded on `acc_kind` as 00 fetch, 01 load, 10 store and 11 load. The stored flags sit at bit 0 V, bit 1 X, bit 2 W and bit 3 R. A missing entry, or an entry with V=0, gives cause 00. Otherwise a fetch without X gives 01, a store without W gives 10, and a load without R gives 11.
- R5: On the clock edge that ends a faulting access, the trap address register takes bits 31..2 of the virtual address with the cause in bits 1..0. This capture takes precedence over a software write to the register in the same cycle.
- R6: `map_rd_data` returns the entry for the page in bits 31..12 of the trap address register. That word holds the physical page in 31..12 and C,R,W,X,V in bits 4..0, with every other bit 0. If there is no entry, the word is all zero, so V=0.
- R7: A mapping write whose page already has an entry overwrites that entry and does not use a new slot.
- R8: A mapping write for a page with no entry fills the slot at the round-robin pointer and advances the pointer. With 8 slots, the 9th new page evicts the first page installed.
- R9: A mapping write with bit 5 (G) = 1 and bit 0 (V) = 0 removes every entry and installs nothing.
- R10: A mapping write with G=1 and V=1 is a normal install, and G reads back as 0.
- R11: An access with `acc_valid` low never faults and leaves the trap address register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xlate_on | input | 1 | High bit of the processor level; 1 enables translation |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 00 fetch, 01 load, 10 store, 11 load |
| acc_vaddr | input | 32 | Virtual address of the access |
| acc_paddr | output | 32 | Translated (or passed-through) address |
| acc_fault | output | 1 | Access faults this cycle |
| acc_cause | output | 2 | Fault cause code |
| tma_wr_en | input | 1 | Software write to the trap address register |
| tma_wr_data | input | 32 | Data for that write |
| tma_rd_data | output | 32 | Trap address register contents |
| map_wr_en | input | 1 | Software write to the mapping register |
| map_wr_data | input | 32 | Mapping word: page 31..12, G 5, C 4, R 3, W 2, X 1, V 0 |
| map_rd_data | output | 32 | Entry for the trap address register's page |

## Verification
The assertions assume that all inputs carry known 0/1 values from the first edge after reset. They also take as given that software reads the mapping register only after the trap address register has settled, since the read follows whatever page that register holds. The stimulus drives every input from reset onward to a defined value. It changes the trap address register and writes a mapping in separate cycles, except in the one case aimed at R5, where a fault and a software write meet on purpose.

// File: rtl/ptb_pkg.sv
// Shared types and encodings for the page translation buffer.
// Assumes the mapping word keeps its flags in the low six bits.
package ptb_pkg;

    // Access kinds as driven on acc_kind
    localparam logic [1:0] KIND_FETCH = 2'b00;
    localparam logic [1:0] KIND_LOAD  = 2'b01;
    localparam logic [1:0] KIND_STORE = 2'b10;

    // Fault cause codes (R4)
    localparam logic [1:0] CAUSE_NOENTRY = 2'b00;
    localparam logic [1:0] CAUSE_NOEXEC  = 2'b01;
    localparam logic [1:0] CAUSE_NOWRITE = 2'b10;
    localparam logic [1:0] CAUSE_NOREAD  = 2'b11;

    // Bit positions of flags in the mapping word
    localparam int FLAG_V = 0;
    localparam int FLAG_X = 1;
    localparam int FLAG_W = 2;
    localparam int FLAG_R = 3;
    localparam int FLAG_C = 4;
    localparam int FLAG_G = 5;
    localparam int PERM_W = 5;

    // Stored permission flags, packed in the same order as word bits 4..0
    typedef struct packed {
        logic c;
        logic r;
        logic w;
        logic x;
        logic v;
    } perm_t;

endpackage

// File: rtl/ptb_cam.sv
// Fully associative entry store with two lookup ports.
// Port A serves accesses; port B serves the software page (trap register).
// Assumes the writer never installs a second entry for a page already held,
// so at most one entry matches on either port.
module ptb_cam
    import ptb_pkg::*;
#(
    parameter  int N     = 8,
    parameter  int VPN_W = 20,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] a_vpn,
    output logic             a_hit,
    output logic [VPN_W-1:0] a_ppn,
    output perm_t            a_perm,
    input  logic [VPN_W-1:0] b_vpn,
    output logic             b_hit,
    output logic [IDX_W-1:0] b_idx,
    output logic [VPN_W-1:0] b_ppn,
    output perm_t            b_perm,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [VPN_W-1:0] wr_ppn,
    input  perm_t            wr_perm,
    input  logic             inval_all
);

    logic [N-1:0]     occ_q;
    logic [VPN_W-1:0] tag_q  [N];
    logic [VPN_W-1:0] ppn_q  [N];
    perm_t            perm_q [N];
    logic [N-1:0]     a_match;
    logic [N-1:0]     b_match;

    // Occupancy flags: cleared by reset or global invalidate, set on install (R1, R9)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else if (inval_all) begin
            occ_q <= '0;
        end else if (wr_en) begin
            occ_q[wr_idx] <= 1'b1;
        end
    end

    // Entry payload: written on install, no reset needed
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_vpn;
            ppn_q[wr_idx]  <= wr_ppn;
            perm_q[wr_idx] <= wr_perm;
        end
    end

    // Per-entry comparators on both ports
    for (genvar g = 0; g < N; g++) begin : g_match
        assign a_match[g] = occ_q[g] && (tag_q[g] == a_vpn);
        assign b_match[g] = occ_q[g] && (tag_q[g] == b_vpn);
    end

    // One-hot OR-mux of the matching entry onto each port
    always_comb begin
        a_hit  = |a_match;
        b_hit  = |b_match;
        a_ppn  = '0;
        a_perm = '0;
        b_ppn  = '0;
        b_perm = '0;
        b_idx  = '0;
        for (int i = 0; i < N; i++) begin
            if (a_match[i]) begin
                a_ppn  = a_ppn | ppn_q[i];
                a_perm = a_perm | perm_q[i];
            end
            if (b_match[i]) begin
                b_ppn  = b_ppn | ppn_q[i];
                b_perm = b_perm | perm_q[i];
                b_idx  = b_idx | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ptb_victim.sv
// Round-robin replacement pointer for new installs (R8).
// Assumes N is at least 2; it advances only when a new page takes a slot.
module ptb_victim #(
    parameter  int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] slot
);

    // Pointer starts at slot 0 and wraps after the last slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (advance) begin
            slot <= (slot == IDX_W'(N - 1)) ? '0 : slot + 1'b1;
        end
    end

endmodule

// File: rtl/ptb_perm.sv
// Permission check: decides whether an access faults and with which cause.
// Assumes the lookup result belongs to the page of the current access.
module ptb_perm
    import ptb_pkg::*;
(
    input  logic       acc_valid,
    input  logic       xlate_on,
    input  logic [1:0] kind,
    input  logic       hit,
    input  perm_t      perm,
    output logic       fault,
    output logic [1:0] cause
);

    // Cause priority: missing/invalid first, then the right for this kind (R4)
    always_comb begin
        fault = 1'b0;
        cause = CAUSE_NOENTRY;
        if (acc_valid && xlate_on) begin
            if (!hit || !perm.v) begin
                fault = 1'b1;
                cause = CAUSE_NOENTRY;
            end else if (kind == KIND_FETCH) begin
                fault = !perm.x;
                cause = CAUSE_NOEXEC;
            end else if (kind == KIND_STORE) begin
                fault = !perm.w;
                cause = CAUSE_NOWRITE;
            end else begin
                fault = !perm.r;
                cause = CAUSE_NOREAD;
            end
        end
    end

endmodule

// File: rtl/ptb_top.sv
// Software-loaded page translation buffer.
// Translates accesses through a small associative store, reports faults into
// the trap address register, and lets software read and install entries for
// the page held in that register. Assumes OFF_W >= 6 so the flags fit below
// the page number.
module ptb_top
    import ptb_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int N_ENTRIES = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            xlate_on,
    input  logic            acc_valid,
    input  logic [1:0]      acc_kind,
    input  logic [VA_W-1:0] acc_vaddr,
    output logic [VA_W-1:0] acc_paddr,
    output logic            acc_fault,
    output logic [1:0]      acc_cause,
    input  logic            tma_wr_en,
    input  logic [VA_W-1:0] tma_wr_data,
    output logic [VA_W-1:0] tma_rd_data,
    input  logic            map_wr_en,
    input  logic [VA_W-1:0] map_wr_data,
    output logic [VA_W-1:0] map_rd_data
);

    localparam int VPN_W = VA_W - OFF_W;
    localparam int IDX_W = $clog2(N_ENTRIES);
    localparam int GAP_W = OFF_W - PERM_W;

    logic             a_hit, b_hit;
    logic [VPN_W-1:0] a_ppn, b_ppn;
    perm_t            a_perm, b_perm, wr_perm;
    logic [IDX_W-1:0] b_idx, victim, wr_idx;
    logic             inval_all, install, advance;
    logic [VA_W-1:0]  tma_q;

    // Decode of a mapping write: global invalidate or install (R7-R10)
    always_comb begin
        inval_all = map_wr_en && map_wr_data[FLAG_G] && !map_wr_data[FLAG_V];
        install   = map_wr_en && !inval_all;
        advance   = install && !b_hit;
        wr_idx    = b_hit ? b_idx : victim;
        wr_perm   = perm_t'(map_wr_data[PERM_W-1:0]);
    end

    ptb_cam #(.N(N_ENTRIES), .VPN_W(VPN_W)) cam_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_vpn     (acc_vaddr[VA_W-1:OFF_W]),
        .a_hit     (a_hit),
        .a_ppn     (a_ppn),
        .a_perm    (a_perm),
        .b_vpn     (tma_q[VA_W-1:OFF_W]),
        .b_hit     (b_hit),
        .b_idx     (b_idx),
        .b_ppn     (b_ppn),
        .b_perm    (b_perm),
        .wr_en     (install),
        .wr_idx    (wr_idx),
        .wr_vpn    (tma_q[VA_W-1:OFF_W]),
        .wr_ppn    (map_wr_data[VA_W-1:OFF_W]),
        .wr_perm   (wr_perm),
        .inval_all (inval_all)
    );

    ptb_victim #(.N(N_ENTRIES)) victim_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .slot    (victim)
    );

    ptb_perm perm_i (
        .acc_valid (acc_valid),
        .xlate_on  (xlate_on),
        .kind      (acc_kind),
        .hit       (a_hit),
        .perm      (a_perm),
        .fault     (acc_fault),
        .cause     (acc_cause)
    );

    // Address out: substitute the page on a hit in translate mode (R2, R3)
    always_comb begin
        if (xlate_on && a_hit) begin
            acc_paddr = {a_ppn, acc_vaddr[OFF_W-1:0]};
        end else begin
            acc_paddr = acc_vaddr;
        end
    end

    // Trap address register: fault capture beats a software write (R1, R5, R11)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tma_q <= '0;
        end else if (acc_fault) begin
            tma_q <= {acc_vaddr[VA_W-1:2], acc_cause};
        end else if (tma_wr_en) begin
            tma_q <= tma_wr_data;
        end
    end

    // Read views: trap register and the entry for its page (R6)
    always_comb begin
        tma_rd_data = tma_q;
        if (b_hit) begin
            map_rd_data = {b_ppn, {GAP_W{1'b0}}, b_perm};
        end else begin
            map_rd_data = '0;
        end
    end

endmodule

// File: rtl/ptb_checker.sv
// Port-level properties of the translation buffer, bound into ptb_top.
// Assumes all inputs are known after reset.
module ptb_checker #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            xlate_on,
    input logic            acc_valid,
    input logic [VA_W-1:0] acc_vaddr,
    input logic [VA_W-1:0] acc_paddr,
    input logic            acc_fault,
    input logic [1:0]      acc_cause,
    input logic [VA_W-1:0] tma_rd_data,
    input logic            map_wr_en,
    input logic [VA_W-1:0] map_wr_data,
    input logic [VA_W-1:0] map_rd_data
);

    a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !xlate_on |-> (acc_paddr == acc_vaddr) && !acc_fault);

    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        acc_paddr[OFF_W-1:0] == acc_vaddr[OFF_W-1:0]);

    a_r5_fault_capture: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |=> tma_rd_data == {$past(acc_vaddr[VA_W-1:2]), $past(acc_cause)});

    a_r11_idle_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !acc_fault);

    a_r9_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
        (map_wr_en && map_wr_data[5] && !map_wr_data[0]) |=> map_rd_data == '0);

    a_r6_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        map_rd_data[OFF_W-1:5] == '0);

endmodule

bind ptb_top ptb_checker #(.VA_W(VA_W), .OFF_W(OFF_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .xlate_on    (xlate_on),
    .acc_valid   (acc_valid),
    .acc_vaddr   (acc_vaddr),
    .acc_paddr   (acc_paddr),
    .acc_fault   (acc_fault),
    .acc_cause   (acc_cause),
    .tma_rd_data (tma_rd_data),
    .map_wr_en   (map_wr_en),
    .map_wr_data (map_wr_data),
    .map_rd_data (map_rd_data)
);

// File: tb/ptb_top_tb_top.sv
// Bench: behavioural reference model compared with the design every cycle.
module ptb_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_on = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_kind = 2'b00;
    logic [31:0] acc_vaddr = '0;
    logic [31:0] acc_paddr;
    logic        acc_fault;
    logic [1:0]  acc_cause;
    logic        tma_wr_en = 1'b0;
    logic [31:0] tma_wr_data = '0;
    logic [31:0] tma_rd_data;
    logic        map_wr_en = 1'b0;
    logic [31:0] map_wr_data = '0;
    logic [31:0] map_rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Reference state
    logic [19:0] m_tag [8];
    logic [31:0] m_dat [8];
    bit          m_occ [8];
    int          m_ptr;
    logic [31:0] m_tma;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ptb_top dut_i (
        .clk(clk), .rst_n(rst_n), .xlate_on(xlate_on), .acc_valid(acc_valid),
        .acc_kind(acc_kind), .acc_vaddr(acc_vaddr), .acc_paddr(acc_paddr),
        .acc_fault(acc_fault), .acc_cause(acc_cause), .tma_wr_en(tma_wr_en),
        .tma_wr_data(tma_wr_data), .tma_rd_data(tma_rd_data),
        .map_wr_en(map_wr_en), .map_wr_data(map_wr_data), .map_rd_data(map_rd_data)
    );

    function automatic int m_find(logic [19:0] vpn);
        for (int i = 0; i < 8; i++) if (m_occ[i] && m_tag[i] == vpn) return i;
        return -1;
    endfunction

    function automatic logic [31:0] exp_paddr();
        int i = m_find(acc_vaddr[31:12]);
        if (xlate_on && i >= 0) return {m_dat[i][31:12], acc_vaddr[11:0]};
        return acc_vaddr;
    endfunction

    function automatic logic [2:0] exp_fault();  // {fault, cause}
        int i = m_find(acc_vaddr[31:12]);
        if (!acc_valid || !xlate_on) return 3'b000;
        if (i < 0 || !m_dat[i][0]) return 3'b100;
        if (acc_kind == 2'b00) return {!m_dat[i][1], 2'b01};
        if (acc_kind == 2'b10) return {!m_dat[i][2], 2'b10};
        return {!m_dat[i][3], 2'b11};
    endfunction

    function automatic logic [31:0] exp_rd();
        int i = m_find(m_tma[31:12]);
        return (i >= 0) ? (m_dat[i] & 32'hFFFF_F01F) : 32'h0;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Advance the reference model across one clock edge using current inputs
    task automatic model_edge();
        logic [2:0] fc = exp_fault();
        int         hit = m_find(m_tma[31:12]);
        logic [19:0] pg = m_tma[31:12];
        if (map_wr_en) begin
            if (map_wr_data[5] && !map_wr_data[0]) begin
                for (int i = 0; i < 8; i++) m_occ[i] = 0;
            end else begin
                int slot = (hit >= 0) ? hit : m_ptr;
                if (hit < 0) m_ptr = (m_ptr + 1) % 8;
                m_occ[slot] = 1;
                m_tag[slot] = pg;
                m_dat[slot] = map_wr_data;
            end
        end
        if (fc[2]) m_tma = {acc_vaddr[31:2], fc[1:0]};
        else if (tma_wr_en) m_tma = tma_wr_data;
    endtask

    // One cycle: drive, compare every output, take the edge, update the model
    task automatic step(string tag, logic xo, logic av, logic [1:0] k, logic [31:0] va,
                        logic tw, logic [31:0] td, logic mw, logic [31:0] md);
        logic [2:0] fc;
        xlate_on = xo; acc_valid = av; acc_kind = k; acc_vaddr = va;
        tma_wr_en = tw; tma_wr_data = td; map_wr_en = mw; map_wr_data = md;
        #1;
        fc = exp_fault();
        chk(tag, "paddr", acc_paddr, exp_paddr());
        chk(tag, "fault", {31'b0, acc_fault}, {31'b0, fc[2]});
        if (fc[2]) chk(tag, "cause", {30'b0, acc_cause}, {30'b0, fc[1:0]});
        chk(tag, "tma", tma_rd_data, m_tma);
        chk(tag, "map_rd", map_rd_data, exp_rd());
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic set_tma(string tag, logic [19:0] pg);
        step(tag, 1'b0, 1'b0, 2'b00, 32'h0, 1'b1, {pg, 12'h000}, 1'b0, 32'h0);
    endtask

    task automatic map_wr(string tag, logic [31:0] d);
        step(tag, 1'b0, 1'b0, 2'b00, 32'h0, 1'b0, 32'h0, 1'b1, d);
    endtask

    task automatic access(string tag, logic [1:0] k, logic [31:0] va);
        step(tag, 1'b1, 1'b1, k, va, 1'b0, 32'h0, 1'b0, 32'h0);
    endtask

    task automatic install(string tag, logic [19:0] pg, logic [31:0] d);
        set_tma(tag, pg);
        map_wr(tag, d);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_occ[i] = 0; m_tag[i] = '0; m_dat[i] = '0;
        end
        m_ptr = 0;
        m_tma = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, empty buffer and cleared trap register
        step("R1", 1'b1, 1'b0, 2'b00, 32'h0000_1234, 1'b0, 32'h0, 1'b0, 32'h0);

        // R2: translation off, addresses pass straight through
        step("R2", 1'b0, 1'b1, 2'b10, 32'hDEAD_BEEF, 1'b0, 32'h0, 1'b0, 32'h0);
        step("R2", 1'b0, 1'b1, 2'b00, 32'h0000_0FFC, 1'b0, 32'h0, 1'b0, 32'h0);

        // R6, R3: install a full-permission page, read it back, translate
        install("R6", 20'h12345, 32'hABCDE01F);
        access("R3", 2'b00, 32'h1234_5A6C);
        access("R3", 2'b01, 32'h1234_5000);
        access("R3", 2'b10, 32'h1234_5FFF);

        // R4: V-only page, each kind lacking its right
        install("R4", 20'h00042, 32'h7777_7001);
        access("R4", 2'b00, 32'h0004_2010);
        access("R4", 2'b10, 32'h0004_2020);
        access("R4", 2'b01, 32'h0004_2030);
        access("R4", 2'b11, 32'h0004_2034);
        // R4: no entry, and an entry with V=0
        access("R4", 2'b01, 32'h0009_9000);
        install("R4", 20'h00050, 32'h1111_100E);
        access("R4", 2'b00, 32'h0005_0004);

        // R5: fault and software trap write in the same cycle
        step("R5", 1'b1, 1'b1, 2'b10, 32'h0008_8124, 1'b1, 32'h5555_5000, 1'b0, 32'h0);
        step("R5", 1'b0, 1'b0, 2'b00, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);

        // R11: no valid access, no fault and trap register untouched
        set_tma("R11", 20'h12345);
        step("R11", 1'b1, 1'b0, 2'b01, 32'h0009_9000, 1'b0, 32'h0, 1'b0, 32'h0);
        step("R11", 1'b1, 1'b0, 2'b01, 32'h0009_9000, 1'b0, 32'h0, 1'b0, 32'h0);

        // R7: overwrite the existing page with new frame and rights
        map_wr("R7", 32'h2222_2009);
        access("R7", 2'b01, 32'h1234_5ABC);
        access("R7", 2'b10, 32'h1234_5ABC);

        // R8: nine new pages; the oldest is evicted
        for (int p = 0; p < 9; p++) install("R8", 20'hA0000 + 20'(p), 32'h3000_000F + (p << 12));
        set_tma("R8", 20'h12345);
        step("R8", 1'b0, 1'b0, 2'b00, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
        access("R8", 2'b01, 32'hA000_8004);
        access("R8", 2'b01, 32'hA000_0004);

        // R10: G=1 with V=1 installs, G reads back as 0
        install("R10", 20'hBEEF0, 32'h4444_403F);
        step("R10", 1'b1, 1'b1, 2'b01, 32'hBEEF_0100, 1'b0, 32'h0, 1'b0, 32'h0);

        // R9: global invalidate empties everything
        map_wr("R9", 32'h0000_0020);
        step("R9", 1'b1, 1'b1, 2'b01, 32'hBEEF_0100, 1'b0, 32'h0, 1'b0, 32'h0);
        access("R9", 2'b00, 32'hA000_8004);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: an overrun counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule